// File: doc/BRIEF.md
# Power-Mode Sequencer

This block selects the power state of a small microcontroller and turns that state into enable lines for each power and clock domain. The domains are the CPU clock, flash, SRAM power and SRAM retention, peripheral clocks, the high-speed and low-speed clocks, watchdog run and pause, brownout duty-cycling and the I/O pad latch. Software picks a target mode with a two-bit request code and then pulses a sleep trigger. Interrupts, an RTC event, wake-enabled GPIO pins and the reset pin bring the block back, and each mode accepts its own set of these sources.

Entry into standby or shutdown takes a snapshot of the GPIO levels. From that point a pin wake means that a wake-enabled pin differs from its snapshot value. A pin wake from shutdown is treated as a full reset and is logged in a sticky reset-cause register. Bits in that register are cleared by writing 1 to them. Standby resumes without a reset through a short sequence. The high-speed clock is restarted first, and the CPU clock and the pad release follow once the clock reports ready.

Top module: `pmc_top`

## Requirements
- R1: While `rst_n` is low and after it is released, `mode_o` is 1 (run), `cause_o` is 3'b001, and the run-mode enables are driven: every enable output is 1 except `sram_ret_o`, `wdt_pause_o`, `bod_duty_o` and `io_latch_o`, which are 0.
- R2: In run mode, a cycle with `sleep_i` high moves `mode_o` on the next cycle according to `mode_req_i`: 2'b01 gives 2 (idle), 2'b10 gives 3 (standby), 2'b11 gives 5 (shutdown), and the invalid code 2'b00 gives idle. `sleep_i` has no effect in any other mode.
- R3: In idle, `cpu_clk_en_o` is 0. Flash, SRAM power, peripheral clocks, both clocks and the watchdog run enable stay 1. `irq_i` or `rtc_evt_i` returns the block to run mode on the next cycle.
- R4: In standby (mode 3), only `sram_ret_o`, `lf_clk_en_o`, `wdt_pause_o`, `bod_duty_o` and `io_latch_o` are 1.
- R5: Standby is left only on `rtc_evt_i` or on a pin wake, where a pin wake is a bit of `pin_i` with `pin_wake_en_i` set that differs from its value in the entry cycle. `irq_i` is ignored.
- R6: A standby wake moves the block to mode 4 (resume). There `hf_clk_en_o` is 1 and the other outputs match standby. The block stays in mode 4 until `hf_ready_i` is seen. On the next cycle it is in run mode, with `cpu_clk_en_o` rising and `io_latch_o` falling together.
- R7: In shutdown (mode 5), only `io_latch_o` is 1. Only a pin wake (as in R5) or the reset pin exits; `irq_i` and `rtc_evt_i` are ignored.
- R8: A pin wake in shutdown returns the block to run mode on the next cycle and sets `cause_o[2]` in that same cycle.
- R9: `rst_pin_i` high in any mode gives `mode_o` = 0 (held) on the next cycle with every enable output 0, and sets `cause_o[1]`. The cycle after release returns the block to run mode.
- R10: `cause_o` bits are sticky. A 1 in `cause_clr_i` clears the matching bit on the next cycle, and a set event in the same cycle wins over the clear.
- R11: A change on a pin whose `pin_wake_en_i` bit is 0 has no effect in standby or shutdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| rst_pin_i | input | 1 | Reset pin held, active high |
| sleep_i | input | 1 | Sleep trigger, sampled in run mode |
| mode_req_i | input | 2 | Requested mode: 01 idle, 10 standby, 11 shutdown, 00 idle |
| irq_i | input | 1 | Any interrupt pending |
| rtc_evt_i | input | 1 | RTC event |
| pin_i | input | NPIN | GPIO pad levels |
| pin_wake_en_i | input | NPIN | Per-pin wake enable |
| hf_ready_i | input | 1 | High-speed clock stable |
| cause_clr_i | input | 3 | Write-1-to-clear strobe for the reset-cause bits |
| mode_o | output | 3 | Mode: 0 held, 1 run, 2 idle, 3 standby, 4 resume, 5 shutdown |
| cause_o | output | 3 | Reset cause: bit0 power-on, bit1 reset pin, bit2 shutdown pin wake |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| flash_en_o | output | 1 | Flash enable |
| sram_on_o | output | 1 | SRAM full power |
| sram_ret_o | output | 1 | SRAM retention |
| periph_clk_en_o | output | 1 | Peripheral clock enable |
| hf_clk_en_o | output | 1 | High-speed clock enable |
| lf_clk_en_o | output | 1 | Low-speed clock enable |
| wdt_run_o | output | 1 | Watchdog running |
| wdt_pause_o | output | 1 | Watchdog paused |
| bod_duty_o | output | 1 | Brownout detector and supply duty-cycled |
| io_latch_o | output | 1 | I/O pads latched |

## Verification
Every enable output is decoded from the registered mode, so a wrong state appears on the eleven enables and on `mode_o` one clock after the input that caused it. A reference model compares all of them on every cycle. A snapshot taken at the wrong time, or a wrong wake mask, shows up as a missed or spurious exit from standby or shutdown in the cycle after the pin stimulus. A cause-register error appears on `cause_o` in the cycle after the set or clear event.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

  typedef enum logic [2:0] {
    PM_HELD   = 3'd0,
    PM_RUN    = 3'd1,
    PM_DOZE   = 3'd2,
    PM_STBY   = 3'd3,
    PM_RESUME = 3'd4,
    PM_OFF    = 3'd5
  } pm_state_e;

  localparam int CAUSE_W    = 3;
  localparam int CAUSE_POR  = 0;
  localparam int CAUSE_PIN  = 1;
  localparam int CAUSE_WAKE = 2;

  typedef struct packed {
    logic cpu;
    logic flash;
    logic sram_on;
    logic sram_ret;
    logic periph;
    logic hf;
    logic lf;
    logic wdt_run;
    logic wdt_pause;
    logic bod_duty;
    logic io_latch;
  } dom_t;

  // Target mode for a sleep request; unknown codes fall back to idle.
  function automatic pm_state_e req_target(input logic [1:0] req);
    case (req)
      2'b10:   return PM_STBY;
      2'b11:   return PM_OFF;
      default: return PM_DOZE;
    endcase
  endfunction

  // Domain enable pattern for each mode.
  function automatic dom_t dom_of(input pm_state_e s);
    dom_t d;
    d = '0;
    case (s)
      PM_RUN: begin
        d.cpu = 1'b1; d.flash = 1'b1; d.sram_on = 1'b1; d.periph = 1'b1;
        d.hf = 1'b1; d.lf = 1'b1; d.wdt_run = 1'b1;
      end
      PM_DOZE: begin
        d.flash = 1'b1; d.sram_on = 1'b1; d.periph = 1'b1;
        d.hf = 1'b1; d.lf = 1'b1; d.wdt_run = 1'b1;
      end
      PM_STBY, PM_RESUME: begin
        d.sram_ret = 1'b1; d.lf = 1'b1; d.wdt_pause = 1'b1;
        d.bod_duty = 1'b1; d.io_latch = 1'b1;
        d.hf = (s == PM_RESUME);
      end
      PM_OFF:  d.io_latch = 1'b1;
      default: d = '0;
    endcase
    return d;
  endfunction

  // True when a mode keeps a pad snapshot alive.
  function automatic logic is_deep(input pm_state_e s);
    return (s == PM_STBY) || (s == PM_OFF);
  endfunction

endpackage

// File: rtl/pmc_wake.sv
module pmc_wake #(
  parameter int NPIN = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            capture_i,
  input  logic [NPIN-1:0] pin_i,
  input  logic [NPIN-1:0] mask_i,
  output logic            chg_o
);
  logic [NPIN-1:0] snap_q;
  logic [NPIN-1:0] diff_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         snap_q <= '0;
    else if (capture_i) snap_q <= pin_i;
  end

  for (genvar g = 0; g < NPIN; g++) begin : g_pin
    assign diff_w[g] = (pin_i[g] ^ snap_q[g]) & mask_i[g];
  end

  assign chg_o = |diff_w;
endmodule

// File: rtl/pmc_fsm.sv
module pmc_fsm
  import pmc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      rst_pin_i,
  input  logic      sleep_i,
  input  logic [1:0] req_i,
  input  logic      irq_i,
  input  logic      rtc_i,
  input  logic      chg_i,
  input  logic      hf_ready_i,
  output pm_state_e state_o,
  output logic      capture_o,
  output logic      shdn_wake_o
);
  pm_state_e state_q, state_d;
  pm_state_e tgt_w;

  assign tgt_w = req_target(req_i);

  always_comb begin
    state_d = state_q;
    if (rst_pin_i) begin
      state_d = PM_HELD;
    end else begin
      case (state_q)
        PM_HELD:   state_d = PM_RUN;
        PM_RUN:    if (sleep_i) state_d = tgt_w;
        PM_DOZE:   if (irq_i || rtc_i) state_d = PM_RUN;
        PM_STBY:   if (rtc_i || chg_i) state_d = PM_RESUME;
        PM_RESUME: if (hf_ready_i) state_d = PM_RUN;
        PM_OFF:    if (chg_i) state_d = PM_RUN;
        default:   state_d = PM_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= PM_RUN;
    else        state_q <= state_d;
  end

  assign capture_o   = !rst_pin_i && (state_q == PM_RUN) && sleep_i && is_deep(tgt_w);
  assign shdn_wake_o = !rst_pin_i && (state_q == PM_OFF) && chg_i;
  assign state_o     = state_q;
endmodule

// File: rtl/pmc_cause.sv
module pmc_cause
  import pmc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               set_pin_i,
  input  logic               set_wake_i,
  input  logic [CAUSE_W-1:0] clr_i,
  output logic [CAUSE_W-1:0] cause_o
);
  logic [CAUSE_W-1:0] cause_q;
  logic [CAUSE_W-1:0] set_w;

  always_comb begin
    set_w             = '0;
    set_w[CAUSE_PIN]  = set_pin_i;
    set_w[CAUSE_WAKE] = set_wake_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q            <= '0;
      cause_q[CAUSE_POR] <= 1'b1;
    end else begin
      cause_q <= (cause_q & ~clr_i) | set_w;
    end
  end

  assign cause_o = cause_q;
endmodule

// File: rtl/pmc_domain.sv
module pmc_domain
  import pmc_pkg::*;
(
  input  pm_state_e state_i,
  output dom_t      dom_o
);
  assign dom_o = dom_of(state_i);
endmodule

// File: rtl/pmc_top.sv
module pmc_top
  import pmc_pkg::*;
#(
  parameter int NPIN = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rst_pin_i,
  input  logic            sleep_i,
  input  logic [1:0]      mode_req_i,
  input  logic            irq_i,
  input  logic            rtc_evt_i,
  input  logic [NPIN-1:0] pin_i,
  input  logic [NPIN-1:0] pin_wake_en_i,
  input  logic            hf_ready_i,
  input  logic [2:0]      cause_clr_i,
  output logic [2:0]      mode_o,
  output logic [2:0]      cause_o,
  output logic            cpu_clk_en_o,
  output logic            flash_en_o,
  output logic            sram_on_o,
  output logic            sram_ret_o,
  output logic            periph_clk_en_o,
  output logic            hf_clk_en_o,
  output logic            lf_clk_en_o,
  output logic            wdt_run_o,
  output logic            wdt_pause_o,
  output logic            bod_duty_o,
  output logic            io_latch_o
);
  pm_state_e state_w;
  dom_t      dom_w;
  logic      wake_chg_w;
  logic      capture_w;
  logic      shdn_wake_w;

  pmc_wake #(.NPIN(NPIN)) u_wake (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture_i (capture_w),
    .pin_i     (pin_i),
    .mask_i    (pin_wake_en_i),
    .chg_o     (wake_chg_w)
  );

  pmc_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .rst_pin_i   (rst_pin_i),
    .sleep_i     (sleep_i),
    .req_i       (mode_req_i),
    .irq_i       (irq_i),
    .rtc_i       (rtc_evt_i),
    .chg_i       (wake_chg_w),
    .hf_ready_i  (hf_ready_i),
    .state_o     (state_w),
    .capture_o   (capture_w),
    .shdn_wake_o (shdn_wake_w)
  );

  pmc_cause u_cause (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_pin_i  (rst_pin_i),
    .set_wake_i (shdn_wake_w),
    .clr_i      (cause_clr_i),
    .cause_o    (cause_o)
  );

  pmc_domain u_dom (
    .state_i (state_w),
    .dom_o   (dom_w)
  );

  assign mode_o          = state_w;
  assign cpu_clk_en_o    = dom_w.cpu;
  assign flash_en_o      = dom_w.flash;
  assign sram_on_o       = dom_w.sram_on;
  assign sram_ret_o      = dom_w.sram_ret;
  assign periph_clk_en_o = dom_w.periph;
  assign hf_clk_en_o     = dom_w.hf;
  assign lf_clk_en_o     = dom_w.lf;
  assign wdt_run_o       = dom_w.wdt_run;
  assign wdt_pause_o     = dom_w.wdt_pause;
  assign bod_duty_o      = dom_w.bod_duty;
  assign io_latch_o      = dom_w.io_latch;
endmodule

// File: rtl/pmc_chk.sv
module pmc_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rst_pin_i,
  input logic       irq_i,
  input logic       rtc_evt_i,
  input logic       hf_ready_i,
  input logic [2:0] mode_o,
  input logic [2:0] cause_o,
  input logic       cpu_clk_en_o,
  input logic       hf_clk_en_o,
  input logic       io_latch_o,
  input logic       wake_chg_w,
  input logic       shdn_wake_w
);
  AST_HELD_ON_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pin_i |=> (mode_o == 3'd0 && !cpu_clk_en_o && !hf_clk_en_o && cause_o[1])); // R9
  AST_DOZE_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 3'd2 && (irq_i || rtc_evt_i) && !rst_pin_i) |=> mode_o == 3'd1); // R3
  AST_STBY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 3'd3 && !rtc_evt_i && !wake_chg_w && !rst_pin_i) |=> mode_o == 3'd3); // R5
  AST_RESUME_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 3'd4 && !hf_ready_i && !rst_pin_i) |=> (mode_o == 3'd4 && !cpu_clk_en_o)); // R6
  AST_CPU_HAS_HF: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_clk_en_o |-> (hf_clk_en_o && !io_latch_o)); // R6
  AST_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 3'd5 && !wake_chg_w && !rst_pin_i) |=> mode_o == 3'd5); // R7
  AST_OFF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    shdn_wake_w |=> (cause_o[2] && mode_o == 3'd1)); // R8
endmodule

bind pmc_top pmc_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rst_pin_i    (rst_pin_i),
  .irq_i        (irq_i),
  .rtc_evt_i    (rtc_evt_i),
  .hf_ready_i   (hf_ready_i),
  .mode_o       (mode_o),
  .cause_o      (cause_o),
  .cpu_clk_en_o (cpu_clk_en_o),
  .hf_clk_en_o  (hf_clk_en_o),
  .io_latch_o   (io_latch_o),
  .wake_chg_w   (wake_chg_w),
  .shdn_wake_w  (shdn_wake_w)
);

// File: tb/pmc_top_tb.sv
`timescale 1ns/1ps
module pmc_top_tb;
  localparam int NPIN = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rst_pin_i = 1'b0, sleep_i = 1'b0, irq_i = 1'b0, rtc_evt_i = 1'b0, hf_ready_i = 1'b0;
  logic [1:0] mode_req_i = 2'b00;
  logic [NPIN-1:0] pin_i = '0, pin_wake_en_i = '0;
  logic [2:0] cause_clr_i = 3'b000;
  logic [2:0] mode_o, cause_o;
  logic cpu_clk_en_o, flash_en_o, sram_on_o, sram_ret_o, periph_clk_en_o, hf_clk_en_o;
  logic lf_clk_en_o, wdt_run_o, wdt_pause_o, bod_duty_o, io_latch_o;

  always #2.5 clk = ~clk;

  pmc_top #(.NPIN(NPIN)) u_dut (.*);

  int checks = 0, errors = 0, cyc = 0;
  int m_st = 1;
  logic [2:0] m_cause = 3'b001;
  logic [NPIN-1:0] m_snap = '0;

  // Model: advance one clock using the inputs held over that edge.
  task automatic model_step();
    logic [2:0] setm;
    bit pinwake;
    setm = 3'b000;
    pinwake = ((pin_i ^ m_snap) & pin_wake_en_i) != 0;
    if (rst_pin_i) begin
      m_st = 0; setm[1] = 1'b1;
    end else if (m_st == 0) m_st = 1;
    else if (m_st == 1) begin
      if (sleep_i) begin
        if (mode_req_i == 2'b10) begin m_st = 3; m_snap = pin_i; end
        else if (mode_req_i == 2'b11) begin m_st = 5; m_snap = pin_i; end
        else m_st = 2;
      end
    end else if (m_st == 2) begin
      if (irq_i || rtc_evt_i) m_st = 1;
    end else if (m_st == 3) begin
      if (rtc_evt_i || pinwake) m_st = 4;
    end else if (m_st == 4) begin
      if (hf_ready_i) m_st = 1;
    end else if (m_st == 5) begin
      if (pinwake) begin m_st = 1; setm[2] = 1'b1; end
    end
    m_cause = (m_cause & ~cause_clr_i) | setm;
  endtask

  function automatic logic [10:0] expect_dom(int s);
    bit run, doze, sb, rs, off;
    run = (s == 1); doze = (s == 2); sb = (s == 3); rs = (s == 4); off = (s == 5);
    return {run, run|doze, run|doze, sb|rs, run|doze, run|doze|rs,
            run|doze|sb|rs, run|doze, sb|rs, sb|rs, sb|rs|off};
  endfunction

  task automatic compare(string tag);
    logic [10:0] act;
    act = {cpu_clk_en_o, flash_en_o, sram_on_o, sram_ret_o, periph_clk_en_o, hf_clk_en_o,
           lf_clk_en_o, wdt_run_o, wdt_pause_o, bod_duty_o, io_latch_o};
    checks++;
    if (mode_o !== m_st[2:0] || act !== expect_dom(m_st) || cause_o !== m_cause) begin
      errors++;
      $display("FAIL %s: mode=%0d dom=%b cause=%b expected mode=%0d dom=%b cause=%b",
               tag, mode_o, act, cause_o, m_st, expect_dom(m_st), m_cause);
    end
  endtask

  task automatic tick(string tag);
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare(tag);
  endtask

  task automatic expect_mode(string tag, int m);
    checks++;
    if (mode_o !== m[2:0]) begin
      errors++;
      $display("FAIL %s: mode=%0d expected %0d", tag, mode_o, m);
    end
  endtask

  task automatic clear_all();
    sleep_i = 0; irq_i = 0; rtc_evt_i = 0; hf_ready_i = 0; rst_pin_i = 0; cause_clr_i = 0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    pin_wake_en_i = 8'b0000_0101;
    @(negedge clk); @(negedge clk);
    compare("R1");
    rst_n = 1'b1;
    tick("R1");
    expect_mode("R1", 1);

    // idle via 01, wake on irq
    mode_req_i = 2'b01; sleep_i = 1; tick("R2"); expect_mode("R2", 2); clear_all();
    tick("R3");
    sleep_i = 1; mode_req_i = 2'b11; tick("R2"); expect_mode("R2", 2); clear_all();
    irq_i = 1; tick("R3"); expect_mode("R3", 1); clear_all();
    // idle via invalid 00, wake on rtc
    mode_req_i = 2'b00; sleep_i = 1; tick("R2"); expect_mode("R2", 2); clear_all();
    rtc_evt_i = 1; tick("R3"); expect_mode("R3", 1); clear_all();

    // standby, ignore irq and unmasked pin, wake on masked pin
    mode_req_i = 2'b10; sleep_i = 1; tick("R4"); expect_mode("R4", 3); clear_all();
    irq_i = 1; tick("R5"); clear_all();
    pin_i[1] = 1'b1; tick("R11"); tick("R11"); expect_mode("R11", 3);
    pin_i[2] = 1'b1; tick("R5"); expect_mode("R5", 4);
    for (int i = 0; i < 3; i++) tick("R6");
    expect_mode("R6", 4);
    hf_ready_i = 1; tick("R6"); expect_mode("R6", 1); clear_all();
    tick("R6");

    // standby, rtc wake; snapshot now holds pin[2]=1
    sleep_i = 1; tick("R4"); clear_all();
    tick("R5");
    rtc_evt_i = 1; tick("R5"); clear_all();
    hf_ready_i = 1; tick("R6"); clear_all();

    // shutdown, ignore irq/rtc/unmasked, wake on masked pin falling
    mode_req_i = 2'b11; sleep_i = 1; tick("R7"); expect_mode("R7", 5); clear_all();
    irq_i = 1; rtc_evt_i = 1; tick("R7"); clear_all();
    pin_i[1] = 1'b0; tick("R11"); expect_mode("R11", 5);
    pin_i[2] = 1'b0; tick("R8"); expect_mode("R8", 1);
    checks++;
    if (cause_o !== 3'b101) begin
      errors++; $display("FAIL R8: cause=%b expected 101", cause_o);
    end
    tick("R8");

    // cause W1C
    cause_clr_i = 3'b100; tick("R10"); clear_all();
    cause_clr_i = 3'b001; tick("R10"); clear_all();
    tick("R10");

    // reset pin in standby, and set beats clear
    mode_req_i = 2'b10; sleep_i = 1; tick("R9"); clear_all();
    rst_pin_i = 1; cause_clr_i = 3'b010; tick("R9"); expect_mode("R9", 0);
    cause_clr_i = 0; tick("R10"); clear_all();
    tick("R9"); expect_mode("R9", 1);
    // reset pin in shutdown and in idle
    mode_req_i = 2'b11; sleep_i = 1; tick("R9"); clear_all();
    rst_pin_i = 1; tick("R9"); clear_all(); tick("R9");
    mode_req_i = 2'b01; sleep_i = 1; tick("R9"); clear_all();
    rst_pin_i = 1; tick("R9"); clear_all(); tick("R9");
    cause_clr_i = 3'b111; tick("R10"); clear_all(); tick("R10");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule